// File: doc/BRIEF.md
# Lockable Management-Memory Visibility Controller

This block decides which copies of a protected management-memory area can be seen by ordinary accesses and which can be seen by accesses made in management mode. Two 8-bit control registers hold the state: a main register, which carries the open, closed, lock and global-enable flags, and an extended register, which carries the high-enable flag and the controls for a segment at the top of low memory. Software writes both registers one byte at a time. Each write passes through a per-register write mask.

From the stored bits the block drives four window enables and a segment description. The four enables are normal-mode low RAM, normal-mode high alias, management-mode low and management-mode high. The segment description gives the segment size, its base (top of low memory minus the size) and an enable for the normal-access blackhole. Inside that blackhole, ordinary reads return all ones and ordinary writes are dropped, while management mode reaches the RAM behind it. The high alias sits at the address given by parameter `HIGH_ALIAS_BASE` (0xFEDA0000 by default).

Setting the lock bit is a one-way step. It clears the open bit and leaves only global-enable writable until the next reset. The memory-routing datapaths are outside this block.

Top module: `smm_vis_ctrl`

## Requirements
- R1: After reset, the main register reads 0x0A and the extended register reads 0x00. In that state low RAM and the high alias are both off in normal mode, the management low window is on, the management high window is off, and the segment size is 0.
- R2: A write whose address equals `MAIN_OFS` (default 0x40) or `EXT_OFS` (default 0x41) updates that register at the clock edge that samples it. A write to any other address changes neither register. `rd_data` shows the addressed register combinationally and shows 0 for any other address.
- R3: Before lock, the main register takes written bits 6 (open), 5 (closed), 4 (lock) and 3 (global-enable). Its bit 7 reads 0 and its bits 2:0 read 3'b010. The extended register takes written bits 7 (high-enable), 2:1 (size code) and 0 (segment-enable), and its bits 6:3 read 0.
- R4: A write that leaves bit 4 set also clears bit 6 in the same update.
- R5: While locked, only main bit 3 is writable. The extended register and the rest of the main register hold their values.
- R6: In normal mode, low RAM is shown exactly when open is set and high-enable is clear. The high alias is shown exactly when open and high-enable are both set.
- R7: In management mode, the low window equals global-enable AND NOT high-enable. The high window equals global-enable AND high-enable.
- R8: With segment-enable set, size code 0/1/2/3 gives 1, 2, 8 or `EXT_SEG_MB` (default 16) MiB, expressed in bytes. With segment-enable clear, the size is 0.
- R9: `seg_base` equals `tolom` minus `seg_size`. `seg_hole_en` is set exactly when the size is nonzero.
- R10: Reset clears lock and restores the write masks that apply before lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 8 | Write byte |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Addressed register contents |
| tolom | input | MEM_W | Top of low memory, in bytes |
| nrm_low_ram_en | output | 1 | Normal mode sees RAM in the low window |
| nrm_high_alias_en | output | 1 | Normal mode sees the high alias |
| smm_low_en | output | 1 | Management mode sees the low window |
| smm_high_en | output | 1 | Management mode sees the high window |
| seg_hole_en | output | 1 | Normal-access blackhole over the segment |
| seg_size | output | MEM_W | Segment size in bytes |
| seg_base | output | MEM_W | Segment base address |

## Verification
A write is sampled at one rising edge, and every register and output reflects it right after that edge. The outputs are combinational from the two registers, so no further latency is added. The bench therefore drives each write on a falling edge and checks readback and all outputs on the following falling edge. `rd_data` and the segment outputs are combinational, so they are sampled 1 ns after `rd_addr` or `tolom` change, still inside that low half-cycle.

// File: rtl/smm_vis_pkg.sv
package smm_vis_pkg;
   // main register bit positions
   localparam int unsigned M_OPEN  = 6;
   localparam int unsigned M_CLOSE = 5;
   localparam int unsigned M_LOCK  = 4;
   localparam int unsigned M_GEN   = 3;
   // extended register bit positions
   localparam int unsigned X_HIEN  = 7;
   localparam int unsigned X_SZ_HI = 2;
   localparam int unsigned X_SZ_LO = 1;
   localparam int unsigned X_SEGEN = 0;

   localparam logic [7:0] MAIN_RO_VAL    = 8'h02;
   localparam logic [7:0] MAIN_RST       = 8'h0A;
   localparam logic [7:0] EXT_RST        = 8'h00;
   localparam logic [7:0] MAIN_WMASK     = 8'h78;
   localparam logic [7:0] MAIN_WMASK_LCK = 8'h08;
   localparam logic [7:0] EXT_WMASK      = 8'h87;
   localparam logic [7:0] EXT_WMASK_LCK  = 8'h00;

   typedef enum logic [1:0] {
      SZ_1M  = 2'd0,
      SZ_2M  = 2'd1,
      SZ_8M  = 2'd2,
      SZ_EXT = 2'd3
   } seg_code_e;

   typedef struct packed {
      logic nrm_low_ram;
      logic nrm_high_alias;
      logic smm_low;
      logic smm_high;
   } win_en_t;
endpackage

// File: rtl/smm_vis_regs.sv
module smm_vis_regs
   import smm_vis_pkg::*;
#(
   parameter int unsigned      ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] MAIN_OFS = 'h40,
   parameter logic [ADDR_W-1:0] EXT_OFS  = 'h41
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic [7:0]        main_q,
   output logic [7:0]        ext_q
);
   logic       locked;
   logic [7:0] main_mask, ext_mask;
   logic [7:0] main_n, ext_n;
   logic       hit_main, hit_ext;

   assign locked    = main_q[M_LOCK];
   assign main_mask = locked ? MAIN_WMASK_LCK : MAIN_WMASK;
   assign ext_mask  = locked ? EXT_WMASK_LCK  : EXT_WMASK;
   assign hit_main  = wr_en && (wr_addr == MAIN_OFS);
   assign hit_ext   = wr_en && (wr_addr == EXT_OFS);

   always_comb begin
      main_n = main_q;
      if (hit_main) begin
         main_n = (main_q & ~main_mask) | (wr_data & main_mask);
      end
      if (main_n[M_LOCK]) begin
         main_n[M_OPEN] = 1'b0;
      end
      ext_n = ext_q;
      if (hit_ext) begin
         ext_n = (ext_q & ~ext_mask) | (wr_data & ext_mask);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_q <= MAIN_RST;
         ext_q  <= EXT_RST;
      end else begin
         main_q <= main_n;
         ext_q  <= ext_n;
      end
   end

   always_comb begin
      if (rd_addr == MAIN_OFS)     rd_data = main_q;
      else if (rd_addr == EXT_OFS) rd_data = ext_q;
      else                         rd_data = 8'h00;
   end
endmodule

// File: rtl/smm_vis_decode.sv
module smm_vis_decode
   import smm_vis_pkg::*;
(
   input  logic [7:0] main_q,
   input  logic [7:0] ext_q,
   output win_en_t    win
);
   logic open_b, gen_b, hien_b;

   assign open_b = main_q[M_OPEN];
   assign gen_b  = main_q[M_GEN];
   assign hien_b = ext_q[X_HIEN];

   always_comb begin
      if (open_b) begin
         win.nrm_low_ram    = ~hien_b;
         win.nrm_high_alias =  hien_b;
      end else begin
         win.nrm_low_ram    = 1'b0;
         win.nrm_high_alias = 1'b0;
      end
      win.smm_low  = gen_b & ~hien_b;
      win.smm_high = gen_b &  hien_b;
   end
endmodule

// File: rtl/smm_vis_seg.sv
module smm_vis_seg
   import smm_vis_pkg::*;
#(
   parameter int unsigned MEM_W      = 32,
   parameter int unsigned EXT_SEG_MB = 16
) (
   input  logic [7:0]       ext_q,
   input  logic [MEM_W-1:0] tolom,
   output logic [MEM_W-1:0] seg_size,
   output logic [MEM_W-1:0] seg_base,
   output logic             seg_hole_en
);
   localparam int unsigned MIB_SH = 20;
   localparam logic [MEM_W-1:0] SZ_1M_B = MEM_W'(1) << MIB_SH;
   localparam logic [MEM_W-1:0] SZ_2M_B = MEM_W'(2) << MIB_SH;
   localparam logic [MEM_W-1:0] SZ_8M_B = MEM_W'(8) << MIB_SH;

   logic [MEM_W-1:0] ext_bytes;
   seg_code_e        code;

   generate
      if (EXT_SEG_MB == 0) begin : g_no_ext
         assign ext_bytes = '0;
      end else begin : g_ext
         assign ext_bytes = MEM_W'(EXT_SEG_MB) << MIB_SH;
      end
   endgenerate

   assign code = seg_code_e'(ext_q[X_SZ_HI:X_SZ_LO]);

   always_comb begin
      if (!ext_q[X_SEGEN]) begin
         seg_size = '0;
      end else begin
         unique case (code)
            SZ_1M:   seg_size = SZ_1M_B;
            SZ_2M:   seg_size = SZ_2M_B;
            SZ_8M:   seg_size = SZ_8M_B;
            default: seg_size = ext_bytes;
         endcase
      end
   end

   assign seg_base    = tolom - seg_size;
   assign seg_hole_en = |seg_size;
endmodule

// File: rtl/smm_vis_ctrl.sv
module smm_vis_ctrl
   import smm_vis_pkg::*;
#(
   parameter int unsigned       ADDR_W          = 8,
   parameter logic [ADDR_W-1:0] MAIN_OFS        = 'h40,
   parameter logic [ADDR_W-1:0] EXT_OFS         = 'h41,
   parameter int unsigned       MEM_W           = 32,
   parameter int unsigned       EXT_SEG_MB      = 16,
   parameter logic [31:0]       HIGH_ALIAS_BASE = 32'hFEDA_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   input  logic [MEM_W-1:0]  tolom,
   output logic              nrm_low_ram_en,
   output logic              nrm_high_alias_en,
   output logic              smm_low_en,
   output logic              smm_high_en,
   output logic              seg_hole_en,
   output logic [MEM_W-1:0]  seg_size,
   output logic [MEM_W-1:0]  seg_base
);
   localparam int unsigned MAX_EXT_MB = (MEM_W >= 32) ? 4095 : ((1 << (MEM_W - 20)) - 1);

   generate
      if (MAIN_OFS == EXT_OFS) begin : g_bad_ofs
         $error("register offsets must differ");
      end
      if (MEM_W < 24 || MEM_W > 64) begin : g_bad_memw
         $error("MEM_W out of range");
      end
      if (EXT_SEG_MB > MAX_EXT_MB) begin : g_bad_ext
         $error("EXT_SEG_MB does not fit MEM_W");
      end
      if (HIGH_ALIAS_BASE[15:0] != 16'h0) begin : g_bad_alias
         $error("high alias base must be 64 KiB aligned");
      end
   endgenerate

   logic [7:0] main_q, ext_q;
   win_en_t    win;

   smm_vis_regs #(
      .ADDR_W   (ADDR_W),
      .MAIN_OFS (MAIN_OFS),
      .EXT_OFS  (EXT_OFS)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .main_q  (main_q),
      .ext_q   (ext_q)
   );

   smm_vis_decode i_dec (
      .main_q (main_q),
      .ext_q  (ext_q),
      .win    (win)
   );

   smm_vis_seg #(
      .MEM_W      (MEM_W),
      .EXT_SEG_MB (EXT_SEG_MB)
   ) i_seg (
      .ext_q       (ext_q),
      .tolom       (tolom),
      .seg_size    (seg_size),
      .seg_base    (seg_base),
      .seg_hole_en (seg_hole_en)
   );

   assign nrm_low_ram_en    = win.nrm_low_ram;
   assign nrm_high_alias_en = win.nrm_high_alias;
   assign smm_low_en        = win.smm_low;
   assign smm_high_en       = win.smm_high;
endmodule

// File: rtl/smm_vis_chk.sv
module smm_vis_chk #(
   parameter int unsigned MEM_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [7:0]       main_q,
   input logic [7:0]       ext_q,
   input logic             nrm_high_alias_en,
   input logic             nrm_low_ram_en,
   input logic             smm_low_en,
   input logic             smm_high_en,
   input logic             seg_hole_en,
   input logic [MEM_W-1:0] seg_size,
   input logic [MEM_W-1:0] seg_base,
   input logic [MEM_W-1:0] tolom
);
   // R5
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      main_q[4] |=> main_q[4]);
   // R4
   open_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      main_q[4] |-> !main_q[6]);
   // R5
   ext_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      main_q[4] |=> $stable(ext_q));
   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(main_q) && $stable(ext_q)));
   // R7
   smm_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({smm_low_en, smm_high_en}));
   // R6
   nrm_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({nrm_low_ram_en, nrm_high_alias_en}));
   // R9
   seg_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_base + seg_size) == tolom);
   // R9
   seg_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seg_hole_en == (seg_size != '0));
endmodule

bind smm_vis_ctrl smm_vis_chk #(.MEM_W(MEM_W)) i_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .wr_en             (wr_en),
   .main_q            (main_q),
   .ext_q             (ext_q),
   .nrm_high_alias_en (nrm_high_alias_en),
   .nrm_low_ram_en    (nrm_low_ram_en),
   .smm_low_en        (smm_low_en),
   .smm_high_en       (smm_high_en),
   .seg_hole_en       (seg_hole_en),
   .seg_size          (seg_size),
   .seg_base          (seg_base),
   .tolom             (tolom)
);

// File: tb/test_smm_vis_ctrl.sv
`timescale 1ns/1ps
module test_smm_vis_ctrl;
   localparam logic [7:0] MO = 8'h40;
   localparam logic [7:0] XO = 8'h41;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = 8'h00;
   logic [7:0]  wr_data = 8'h00;
   logic [7:0]  rd_addr = 8'h00;
   logic [7:0]  rd_data;
   logic [31:0] tolom = 32'h8000_0000;
   logic        nrm_low_ram_en, nrm_high_alias_en, smm_low_en, smm_high_en, seg_hole_en;
   logic [31:0] seg_size, seg_base;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   int cyc = 0;

   always #2 clk = ~clk;

   smm_vis_ctrl i_smm_vis_ctrl (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data), .tolom (tolom),
      .nrm_low_ram_en (nrm_low_ram_en), .nrm_high_alias_en (nrm_high_alias_en),
      .smm_low_en (smm_low_en), .smm_high_en (smm_high_en),
      .seg_hole_en (seg_hole_en), .seg_size (seg_size), .seg_base (seg_base)
   );

   task automatic cmp(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [31:0] exp_size(input logic [7:0] x);
      if (!x[0]) return 32'h0;
      case (x[2:1])
         2'd0: return 32'd1 << 20;
         2'd1: return 32'd2 << 20;
         2'd2: return 32'd8 << 20;
         default: return 32'd16 << 20;
      endcase
   endfunction

   // check everything against expected register contents (R2 R6 R7 R8 R9)
   task automatic check_all(input string r, input logic [7:0] em, input logic [7:0] ex);
      logic [31:0] sz;
      sz = exp_size(ex);
      rd_addr = MO; #1;
      cmp(r, "main", {24'h0, rd_data}, {24'h0, em});
      rd_addr = XO; #1;
      cmp(r, "ext", {24'h0, rd_data}, {24'h0, ex});
      cmp(r, "R6 low_ram", {31'h0, nrm_low_ram_en}, {31'h0, em[6] & ~ex[7]});
      cmp(r, "R6 alias", {31'h0, nrm_high_alias_en}, {31'h0, em[6] & ex[7]});
      cmp(r, "R7 smm_low", {31'h0, smm_low_en}, {31'h0, em[3] & ~ex[7]});
      cmp(r, "R7 smm_high", {31'h0, smm_high_en}, {31'h0, em[3] & ex[7]});
      cmp(r, "R8 size", seg_size, sz);
      cmp(r, "R9 base", seg_base, tolom - sz);
      cmp(r, "R9 hole", {31'h0, seg_hole_en}, {31'h0, sz != 0});
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] mlist [4];
      mlist = '{8'h00, 8'h08, 8'h40, 8'h48};
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_all("R1", 8'h0A, 8'h00);

      // R2 stray addresses leave registers unchanged
      wr(8'h42, 8'hFF); check_all("R2", 8'h0A, 8'h00);
      wr(8'h3F, 8'hFF); check_all("R2", 8'h0A, 8'h00);
      rd_addr = 8'h10; #1;
      cmp("R2", "other rd", {24'h0, rd_data}, 32'h0);

      // R3 main sweep without lock
      for (int m = 0; m < 256; m++) begin
         logic [7:0] mv;
         mv = 8'(m) & 8'hEF;
         wr(MO, mv);
         check_all("R3", (mv & 8'h78) | 8'h02, 8'h00);
      end

      // R3 R6 R7 R8 R9 extended sweep over two memory tops
      for (int t = 0; t < 2; t++) begin
         tolom = (t == 0) ? 32'h8000_0000 : 32'h4010_0000;
         for (int x = 0; x < 256; x++) begin
            wr(XO, 8'(x));
            for (int k = 0; k < 4; k++) begin
               wr(MO, mlist[k]);
               check_all("R8", mlist[k] | 8'h02, 8'(x) & 8'h87);
            end
         end
      end

      // R4 R5 lock sequence
      tolom = 32'h8000_0000;
      do_reset();
      wr(MO, 8'h48); check_all("R3", 8'h4A, 8'h00);
      wr(XO, 8'h83); check_all("R3", 8'h4A, 8'h83);
      wr(MO, 8'h58); check_all("R4", 8'h1A, 8'h83);
      wr(XO, 8'h00); check_all("R5", 8'h1A, 8'h83);
      wr(MO, 8'h40); check_all("R5", 8'h12, 8'h83);
      wr(MO, 8'h68); check_all("R5", 8'h1A, 8'h83);
      wr(MO, 8'h00); check_all("R5", 8'h12, 8'h83);

      // R10 reset clears lock and restores masks
      do_reset();
      check_all("R10", 8'h0A, 8'h00);
      wr(MO, 8'h40); check_all("R10", 8'h42, 8'h00);
      wr(XO, 8'h85); check_all("R10", 8'h42, 8'h85);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule